// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a chain of boundary-scan cells placed between core logic and the device pins. Every cell has two storage stages: a capture/shift stage that either loads the cell's parallel input or takes part in a serial shift path, and an update stage that holds a test value. A multiplexer in each cell drives the parallel output from either the live parallel input or the held update value.

A parameter mask marks each cell as an output cell or an input cell. An output cell sits between core and pin, and an input cell sits between pin and core. Output cells obey an external-test control. Input cells obey an internal-test control.

The test controller outside the block supplies the strobes:
- A shift or capture strobe, qualified by a clock enable.
- An update strobe.
- The two mode controls.

With both mode controls at 0, the chain can sample live pin and core values while normal traffic flows through unchanged. To test interconnect, a value is shifted in, moved to the update stage by an update strobe, and driven onto the pins by the output cells. The input cells of a receiving device then capture that value.

Top module: `bscan_chain`

## Requirements
- R1: An active-low asynchronous reset clears both stages of every cell to 0, so after reset `scan_out` is 0 and any cell in test mode drives 0.
- R2: A cell whose mode control is 0 drives `par_out[i]` equal to `par_in[i]` in the same cycle, regardless of what its stages hold.
- R3: On a clock edge with `clk_en`=1 and `shift_en`=1, cell 0 loads `scan_in` and each cell i>0 loads the capture value of cell i-1. `scan_out` is always the capture value of the last cell, `CELLS-1`.
- R4: On a clock edge with `clk_en`=1 and `shift_en`=0, every cell's capture stage loads `par_in[i]`.
- R5: On a clock edge with `upd_en`=1, the update stage loads the capture value it held before that edge, unless a shift takes place on the same edge.
- R6: Cell i uses `ext_mode` as its mode control when `OUT_MASK[i]`=1 (output cell) and `int_mode` when `OUT_MASK[i]`=0 (input cell). With its mode control at 1, the cell drives its update value on `par_out[i]`.
- R7: On a clock edge with `clk_en`=0, the capture stages keep their values.
- R8: While shifting, the update stages and therefore the test-driven outputs stay unchanged, even if `upd_en` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Capture/shift clock enable |
| shift_en | input | 1 | 1 selects shift, 0 selects capture |
| upd_en | input | 1 | Update strobe |
| ext_mode | input | 1 | Mode control for output cells |
| int_mode | input | 1 | Mode control for input cells |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data out of the last cell |
| par_in | input | CELLS | Parallel inputs, one per cell |
| par_out | output | CELLS | Parallel outputs, one per cell |

## Verification
The assertions assume that reset is released away from a clock edge and that every control input holds a defined level at each edge. They also assume that the update strobe may coincide with a shift, in which case the shift takes precedence.

The stimulus changes inputs only on the falling clock edge. Each strobe and mode control is drawn independently from a seeded generator, so update-during-shift, capture-with-update and hold cycles all occur. Directed sequences add a full-chain shift, a sample with both modes low, and mixed output-cell and input-cell modes.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int CELLS = 8,
  parameter logic [CELLS-1:0] OUT_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             shift_en,
  input  logic             upd_en,
  input  logic             ext_mode,
  input  logic             int_mode,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [CELLS-1:0] par_in,
  output logic [CELLS-1:0] par_out
);

  logic [CELLS-1:0] cap_q, upd_q, sel;
  logic             shifting;

  assign shifting = clk_en & shift_en;
  assign scan_out = cap_q[CELLS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (clk_en) begin
      if (shift_en) begin
        cap_q[0] <= scan_in;
        for (int i = 1; i < CELLS; i++) cap_q[i] <= cap_q[i-1];
      end else begin
        cap_q <= par_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= '0;
    else if (upd_en && !shifting) upd_q <= cap_q;
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    if (OUT_MASK[g]) begin : g_out
      assign sel[g] = ext_mode;
    end else begin : g_in
      assign sel[g] = int_mode;
    end
    assign par_out[g] = sel[g] ? upd_q[g] : par_in[g];
  end

  AST_SHIFT_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |=> cap_q[0] == $past(scan_in)) else $error("shift entry"); // R3
  AST_CAPTURE_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !shift_en) |=> cap_q == $past(par_in)) else $error("capture"); // R4
  AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !shifting) |=> upd_q == $past(cap_q)) else $error("update"); // R5
  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q)) else $error("update hold"); // R5
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cap_q)) else $error("capture hold"); // R7
  AST_NO_UPD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |=> $stable(upd_q)) else $error("update during shift"); // R8

endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb_top;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'hF0;

  logic clk = 0, rst_n = 0;
  logic clk_en = 0, shift_en = 0, upd_en = 0, ext_mode = 0, int_mode = 0, scan_in = 0;
  logic [N-1:0] par_in = '0;
  logic scan_out;
  logic [N-1:0] par_out;
  logic [N-1:0] cap_m = '0, upd_m = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  bscan_chain #(.CELLS(N), .OUT_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .shift_en(shift_en), .upd_en(upd_en),
    .ext_mode(ext_mode), .int_mode(int_mode), .scan_in(scan_in), .scan_out(scan_out),
    .par_in(par_in), .par_out(par_out));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [N-1:0] exp_out(logic [N-1:0] u, logic [N-1:0] p, logic em, logic im);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (MASK[i] ? em : im) ? u[i] : p[i];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, {31'd0, scan_out}, {31'd0, cap_m[N-1]});
    chk(req, {24'd0, par_out}, {24'd0, exp_out(upd_m, par_in, ext_mode, int_mode)});
  endtask

  task automatic cyc(logic ce, logic se, logic ue, logic si, logic [N-1:0] pi);
    clk_en = ce; shift_en = se; upd_en = ue; scan_in = si; par_in = pi;
    @(posedge clk);
    if (ue && !(ce && se)) upd_m = cap_m;
    if (ce) cap_m = se ? {cap_m[N-2:0], si} : pi;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] held;
    void'($urandom(32'd1234));
    par_in = 8'h3C;
    #(CLK_P * 2 + 3);
    ext_mode = 1; int_mode = 1; #1;
    chk("R1", {31'd0, scan_out}, 32'd0);
    chk("R1", {24'd0, par_out}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R3 R5 R8: shift 0xA5 with update asserted, outputs must hold
    for (int b = 0; b < N; b++) begin
      cyc(1, 1, 1, 1'((8'hA5 >> (N-1-b)) & 1), 8'h0F);
      chk("R8", {24'd0, par_out}, 32'd0);
    end
    chk("R3", {31'd0, scan_out}, 32'd1);
    cyc(0, 0, 1, 0, 8'h0F);
    chk("R5", {24'd0, par_out}, 32'hA5);
    // R6: only output cells in test mode
    ext_mode = 1; int_mode = 0; par_in = 8'h3C; #1;
    chk("R6", {24'd0, par_out}, 32'hAC);
    ext_mode = 0; int_mode = 1; #1;
    chk("R6", {24'd0, par_out}, 32'h35);
    // R2 R4: sample with both modes low
    ext_mode = 0; int_mode = 0;
    cyc(1, 0, 0, 0, 8'h5E);
    chk("R2", {24'd0, par_out}, 32'h5E);
    chk("R4", {31'd0, scan_out}, 32'd0);
    held = 8'h5E;
    cyc(0, 1, 0, 1, 8'hFF);
    chk("R7", {31'd0, scan_out}, {31'd0, held[N-1]});
    cyc(0, 0, 1, 0, 8'h00);
    ext_mode = 1; int_mode = 1; #1;
    chk("R7", {24'd0, par_out}, 32'h5E);

    for (int k = 0; k < 2000; k++) begin
      ext_mode = 1'($urandom_range(0, 1));
      int_mode = 1'($urandom_range(0, 1));
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
      check_all("R2-R8 random: R3 R4 R5 R6 R7");
    end
    finish_run();
  end
endmodule